// File: doc/BRIEF.md
# ADPCM Sound Effect Player

The block plays short sound effects held back to back in a 64 KiB byte memory as 4-bit adaptive differential codes. A request names a sound by a two-bit ID. The block then looks up where that sound starts and how many bytes it has. It reads the bytes one at a time and expands each byte into two 12-bit signed samples, high nibble first. Each sample comes out on a tick of a 12 kHz sample strobe.

There is only one voice. While a sound plays, the block holds `busy_o` high and drops any new request, with one exception. A bell request always wins: it abandons the current sound and starts the bell from its first byte. The decoder state (predicted sample and step index) is cleared at every start, so each sound decodes the same way no matter what played before it.

Top module: `sfx_player`

## Requirements
- R1: After reset, `busy_o` = 0, `sample_o` = 0, `sample_valid_o` = 0 and `mem_addr_o` = 0.
- R2: ID 0 selects keypress (start 0, 4160 bytes), ID 1 selects bell (start 4160, 19854 bytes) and ID 2 selects tape-read (start 24014, 41448 bytes); bases and lengths are parameters. An accepted request puts the sound's start on `mem_addr_o` in the cycle after the request edge. ID 3 is ignored.
- R3: Memory returns the byte for `mem_addr_o` one cycle later. Bytes are read in ascending address order. Each byte gives two codes, bits [7:4] first and then bits [3:0].
- R4: While playing, each strobe edge in which a code is waiting decodes exactly one sample. `sample_valid_o` is high for the single cycle after that edge, and `sample_o` holds the new sample. Strobes must be at least 4 cycles apart.
- R5: The difference is step/8, plus step when code bit 2 is set, plus step/2 when bit 1 is set, plus step/4 when bit 0 is set (integer division). Code bit 3 set means the difference is subtracted from the previous sample.
- R6: The new sample saturates to the range -2048 to 2047.
- R7: The step comes from the standard 49-entry table (16 up to 1552) at the step index. After each code, the index changes by -1 for low 3 bits 0 to 3, and by +2, +4, +6 or +8 for 4, 5, 6 or 7. The index is then clamped to 0 to 48.
- R8: Each accepted request resets the predicted sample and the step index to 0, so `sample_o` reads 0 in the cycle after acceptance.
- R9: `busy_o` is high from the cycle after acceptance until the sample from the low nibble of the last byte appears. It is low in the same cycle that `sample_valid_o` shows that last sample.
- R10: A request for ID 0 or 2 while `busy_o` = 1 has no effect: the address and the sample stream carry on with the current sound.
- R11: A bell request while busy restarts playback at the bell's start with cleared decoder state.
- R12: When an accepted request and a strobe fall in the same cycle, the request wins and no sample is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Play request strobe |
| req_id_i | input | 2 | Sound ID for the request |
| sample_tick_i | input | 1 | 12 kHz sample strobe, one cycle wide |
| mem_addr_o | output | 16 | Sound memory byte address |
| mem_data_i | input | 8 | Byte read from sound memory, one cycle after address |
| busy_o | output | 1 | A sound is playing |
| sample_o | output | 12 | Decoded signed PCM sample |
| sample_valid_o | output | 1 | New sample on `sample_o` this cycle |

## Verification
The decoder is tried with three kinds of memory content, and each one shows up a different kind of fault. The keypress region holds pseudo-random bytes, which mix every code value and catch a wrong sign, magnitude bit or nibble order. The bell region is filled with 0x77 and the tape region with 0xFF, which drive the step index to its upper clamp and the sample into positive and negative saturation. Request collisions are tried as well: requests arriving while busy (dropped versus bell pre-emption), an invalid ID, and a request falling on a strobe cycle, each placed both in directed cases and at random times during playback.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int ID_W = 2;
  localparam logic [ID_W-1:0] SND_KEY  = 2'd0;
  localparam logic [ID_W-1:0] SND_BELL = 2'd1;
  localparam logic [ID_W-1:0] SND_TAPE = 2'd2;
  localparam logic [ID_W-1:0] SND_NONE = 2'd3;

  localparam int IDX_W   = 6;
  localparam int IDX_MAX = 48;
  localparam int STEP_W  = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_WAIT_HI,
    ST_WAIT_LO
  } seq_state_e;

  function automatic logic signed [7:0] idx_adj(input logic [2:0] mag);
    case (mag)
      3'd4:    return 8'sd2;
      3'd5:    return 8'sd4;
      3'd6:    return 8'sd6;
      3'd7:    return 8'sd8;
      default: return -8'sd1;
    endcase
  endfunction
endpackage

// File: rtl/adpcm_step_lut.sv
module adpcm_step_lut
  import sfx_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  output logic [STEP_W-1:0] step_o
);
  always_comb begin
    case (idx_i)
      6'd0:  step_o = 11'd16;   6'd1:  step_o = 11'd17;
      6'd2:  step_o = 11'd19;   6'd3:  step_o = 11'd21;
      6'd4:  step_o = 11'd23;   6'd5:  step_o = 11'd25;
      6'd6:  step_o = 11'd28;   6'd7:  step_o = 11'd31;
      6'd8:  step_o = 11'd34;   6'd9:  step_o = 11'd37;
      6'd10: step_o = 11'd41;   6'd11: step_o = 11'd45;
      6'd12: step_o = 11'd50;   6'd13: step_o = 11'd55;
      6'd14: step_o = 11'd60;   6'd15: step_o = 11'd66;
      6'd16: step_o = 11'd73;   6'd17: step_o = 11'd80;
      6'd18: step_o = 11'd88;   6'd19: step_o = 11'd97;
      6'd20: step_o = 11'd107;  6'd21: step_o = 11'd118;
      6'd22: step_o = 11'd130;  6'd23: step_o = 11'd143;
      6'd24: step_o = 11'd157;  6'd25: step_o = 11'd173;
      6'd26: step_o = 11'd190;  6'd27: step_o = 11'd209;
      6'd28: step_o = 11'd230;  6'd29: step_o = 11'd253;
      6'd30: step_o = 11'd279;  6'd31: step_o = 11'd307;
      6'd32: step_o = 11'd337;  6'd33: step_o = 11'd371;
      6'd34: step_o = 11'd408;  6'd35: step_o = 11'd449;
      6'd36: step_o = 11'd494;  6'd37: step_o = 11'd544;
      6'd38: step_o = 11'd598;  6'd39: step_o = 11'd658;
      6'd40: step_o = 11'd724;  6'd41: step_o = 11'd796;
      6'd42: step_o = 11'd876;  6'd43: step_o = 11'd963;
      6'd44: step_o = 11'd1060; 6'd45: step_o = 11'd1166;
      6'd46: step_o = 11'd1282; 6'd47: step_o = 11'd1411;
      default: step_o = 11'd1552;
    endcase
  end
endmodule

// File: rtl/adpcm_core.sv
module adpcm_core
  import sfx_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       en_i,
  input  logic [3:0]                 code_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int SUM_W = SAMPLE_W + 2;
  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((1 << (SAMPLE_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] S_MIN = -SUM_W'(1 << (SAMPLE_W-1));

  logic signed [SAMPLE_W-1:0] pred_q, pred_d;
  logic [IDX_W-1:0]           idx_q, idx_d;
  logic [STEP_W-1:0]          step;
  logic [SUM_W-2:0]           mag;
  logic signed [SUM_W-1:0]    sum;
  logic signed [7:0]          idx_sum;

  adpcm_step_lut u_lut (.idx_i(idx_q), .step_o(step));

  always_comb begin
    mag = (SUM_W-1)'(step >> 3);
    if (code_i[2]) mag = mag + (SUM_W-1)'(step);
    if (code_i[1]) mag = mag + (SUM_W-1)'(step >> 1);
    if (code_i[0]) mag = mag + (SUM_W-1)'(step >> 2);
    sum = SUM_W'(pred_q);
    if (code_i[3]) sum = sum - $signed({1'b0, mag});
    else           sum = sum + $signed({1'b0, mag});
    if (sum > S_MAX)      pred_d = S_MAX[SAMPLE_W-1:0];
    else if (sum < S_MIN) pred_d = S_MIN[SAMPLE_W-1:0];
    else                  pred_d = sum[SAMPLE_W-1:0];
    idx_sum = $signed({2'b00, idx_q}) + idx_adj(code_i[2:0]);
    if (idx_sum < 0)                 idx_d = '0;
    else if (idx_sum > 8'sd48)       idx_d = IDX_W'(IDX_MAX);
    else                             idx_d = idx_sum[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= '0;
      idx_q  <= '0;
    end else if (clr_i) begin
      pred_q <= '0;
      idx_q  <= '0;
    end else if (en_i) begin
      pred_q <= pred_d;
      idx_q  <= idx_d;
    end
  end

  assign sample_o = pred_q;

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(IDX_MAX)); // R7
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pred_q == '0 && idx_q == '0)); // R8
  AST_POS_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !code_i[3]) |=> pred_q >= $past(pred_q)); // R5
endmodule

// File: rtl/sfx_sequencer.sv
module sfx_sequencer
  import sfx_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_base_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic              tick_i,
  input  logic [7:0]        mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              busy_o,
  output logic              dec_en_o,
  output logic [3:0]        code_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [7:0]        byte_q;
  logic              waiting;

  assign waiting  = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO);
  assign dec_en_o = tick_i && waiting && !start_i;
  assign code_o   = (state_q == ST_WAIT_HI) ? byte_q[7:4] : byte_q[3:0];
  assign busy_o   = (state_q != ST_IDLE);
  assign mem_addr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      remain_q <= '0;
      byte_q   <= '0;
    end else if (start_i) begin
      state_q  <= ST_FETCH;
      ptr_q    <= start_base_i;
      remain_q <= start_len_i;
    end else begin
      case (state_q)
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          byte_q  <= mem_data_i;
          state_q <= ST_WAIT_HI;
        end
        ST_WAIT_HI: if (tick_i) state_q <= ST_WAIT_LO;
        ST_WAIT_LO: if (tick_i) begin
          if (remain_q == LEN_W'(1)) begin
            remain_q <= '0;
            state_q  <= ST_IDLE;
          end else begin
            remain_q <= remain_q - 1'b1;
            ptr_q    <= ptr_q + 1'b1;
            state_q  <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_LO && tick_i && !start_i && remain_q != LEN_W'(1))
    |=> ptr_q == $past(ptr_q) + 1'b1); // R3
  AST_REMAIN_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> remain_q != '0); // R9
endmodule

// File: rtl/sfx_player.sv
module sfx_player
  import sfx_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SAMPLE_W  = 12,
  parameter int KEY_BASE  = 0,
  parameter int KEY_LEN   = 4160,
  parameter int BELL_BASE = 4160,
  parameter int BELL_LEN  = 19854,
  parameter int TAPE_BASE = 24014,
  parameter int TAPE_LEN  = 41448
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [ID_W-1:0]            req_id_i,
  input  logic                       sample_tick_i,
  output logic [ADDR_W-1:0]          mem_addr_o,
  input  logic [7:0]                 mem_data_i,
  output logic                       busy_o,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       sample_valid_o
);
  localparam int LEN_W = ADDR_W + 1;

  logic [ADDR_W-1:0] sel_base;
  logic [LEN_W-1:0]  sel_len;
  logic              sel_ok, start, dec_en;
  logic [3:0]        code;

  always_comb begin
    sel_ok   = 1'b1;
    sel_base = '0;
    sel_len  = '0;
    case (req_id_i)
      SND_KEY:  begin sel_base = ADDR_W'(KEY_BASE);  sel_len = LEN_W'(KEY_LEN);  end
      SND_BELL: begin sel_base = ADDR_W'(BELL_BASE); sel_len = LEN_W'(BELL_LEN); end
      SND_TAPE: begin sel_base = ADDR_W'(TAPE_BASE); sel_len = LEN_W'(TAPE_LEN); end
      default:  sel_ok = 1'b0;
    endcase
    if (sel_len == '0) sel_ok = 1'b0;
  end

  // single voice: only the bell may pre-empt
  assign start = req_valid_i && sel_ok && (!busy_o || req_id_i == SND_BELL);

  sfx_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_base_i(sel_base),
    .start_len_i (sel_len),
    .tick_i      (sample_tick_i),
    .mem_data_i  (mem_data_i),
    .mem_addr_o  (mem_addr_o),
    .busy_o      (busy_o),
    .dec_en_o    (dec_en),
    .code_o      (code)
  );

  adpcm_core #(.SAMPLE_W(SAMPLE_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .en_i    (dec_en),
    .code_i  (code),
    .sample_o(sample_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_valid_o <= 1'b0;
    else         sample_valid_o <= dec_en;
  end

  AST_BELL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_id_i == SND_BELL)
    |=> (busy_o && mem_addr_o == ADDR_W'(BELL_BASE) && sample_o == '0)); // R11
  AST_VALID_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> $past(sample_tick_i)); // R4
  AST_BAD_ID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_id_i == SND_NONE) |=> !busy_o); // R2
  AST_NO_SAMPLE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_id_i == SND_BELL) |=> !sample_valid_o); // R12
endmodule

// File: tb/sfx_player_bench.sv
module sfx_player_bench;
  localparam int KB = 0,     KL = 20;
  localparam int BB = 4160,  BL = 16;
  localparam int TB = 24014, TL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_id = '0;
  logic auto_tick = 1'b0, man_tick = 1'b0, tick_en = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_q = '0;
  logic busy, svalid;
  logic signed [11:0] sample;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sfx_player #(.KEY_BASE(KB), .KEY_LEN(KL), .BELL_BASE(BB), .BELL_LEN(BL),
               .TAPE_BASE(TB), .TAPE_LEN(TL)) u_sfx_player (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_id_i(req_id),
    .sample_tick_i(auto_tick | man_tick), .mem_addr_o(mem_addr),
    .mem_data_i(mem_q), .busy_o(busy), .sample_o(sample),
    .sample_valid_o(svalid));

  function automatic logic [7:0] mem_byte(input int a);
    if (a >= BB && a < BB + BL) return 8'h77;
    if (a >= TB && a < TB + TL) return 8'hFF;
    return 8'((a * 29 + (a >> 2)) ^ 8'hA5);
  endfunction

  always @(posedge clk) mem_q <= mem_byte(int'(mem_addr));

  function automatic int step_of(input int i);
    int t[49] = '{16,17,19,21,23,25,28,31,34,37,41,45,50,55,60,66,73,80,88,97,
                  107,118,130,143,157,173,190,209,230,253,279,307,337,371,408,
                  449,494,544,598,658,724,796,876,963,1060,1166,1282,1411,1552};
    return t[i];
  endfunction

  // model state
  int m_addr, m_left, m_pred, m_idx, cur_base, cur_len;
  bit m_hi, m_active;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int base_of(input int id);
    return id == 0 ? KB : id == 1 ? BB : TB;
  endfunction
  function automatic int len_of(input int id);
    return id == 0 ? KL : id == 1 ? BL : TL;
  endfunction

  // sample tick every 5 cycles
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 5;
    auto_tick = tick_en && (tcnt == 0);
  end

  // sample monitor (R3 R4 R5 R6 R7 R9)
  always @(posedge clk) begin
    #1;
    if (rst_n && svalid) begin
      if (!m_active) check(0, "R4 unexpected sample", int'(sample), 0);
      else begin
        int c, st, d, p;
        logic [7:0] b;
        b = mem_byte(m_addr);
        c = m_hi ? int'(b[7:4]) : int'(b[3:0]);
        st = step_of(m_idx);
        d = st / 8;
        if (c & 4) d += st;
        if (c & 2) d += st / 2;
        if (c & 1) d += st / 4;
        p = (c & 8) ? m_pred - d : m_pred + d;
        if (p > 2047) p = 2047;
        if (p < -2048) p = -2048;
        m_pred = p;
        m_idx += ((c & 7) < 4) ? -1 : 2 * ((c & 7) - 3);
        if (m_idx < 0) m_idx = 0;
        if (m_idx > 48) m_idx = 48;
        check(int'(sample) == p, "R5 R6 R7 sample", int'(sample), p);
        if (!m_hi) begin
          m_left--; m_addr++;
        end
        m_hi = !m_hi;
        if (m_left == 0) begin
          m_active = 0;
          check(busy == 1'b0, "R9 busy after last", int'(busy), 0);
        end else check(busy == 1'b1, "R9 busy during", int'(busy), 1);
      end
    end
  end

  task automatic issue(input int id, input bit with_tick);
    bit acc, was_busy;
    @(negedge clk);
    was_busy = busy;
    acc = (id != 3) && (!busy || id == 1);
    req_valid = 1'b1;
    req_id = 2'(id);
    man_tick = with_tick;
    @(posedge clk);
    #1;
    if (acc) begin
      m_active = 1; m_addr = base_of(id); m_left = len_of(id);
      m_hi = 1; m_pred = 0; m_idx = 0;
      cur_base = base_of(id); cur_len = len_of(id);
      check(int'(mem_addr) == base_of(id), "R2 R11 start address", int'(mem_addr), base_of(id));
      check(sample == 0, "R8 cleared sample", int'(sample), 0);
      check(busy == 1'b1, "R9 busy on accept", int'(busy), 1);
      if (with_tick) check(svalid == 1'b0, "R12 no sample on start", int'(svalid), 0);
    end else if (!was_busy) begin
      check(busy == 1'b0, "R2 id 3 ignored", int'(busy), 0);
    end else begin
      check(int'(mem_addr) >= cur_base && int'(mem_addr) < cur_base + cur_len,
            "R10 request dropped", int'(mem_addr), cur_base);
    end
    @(negedge clk);
    req_valid = 1'b0;
    man_tick = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    check(busy == 1'b0, "R9 returns idle", int'(busy), 0);
    check(!m_active, "R9 all samples seen", int'(m_active), 0);
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_active = 0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy", int'(busy), 0);
    check(sample == 0, "R1 sample", int'(sample), 0);
    check(svalid == 0, "R1 valid", int'(svalid), 0);
    check(mem_addr == 0, "R1 addr", int'(mem_addr), 0);
    rst_n = 1'b1;
    tick_en = 1'b1;
    repeat (2) @(negedge clk);

    issue(3, 0);                  // R2 invalid id while idle
    issue(0, 0); wait_idle();     // R3 pseudo-random codes
    issue(1, 0); wait_idle();     // R6 R7 positive saturation
    check(sample == 12'sd2047, "R6 positive limit", int'(sample), 2047);
    issue(2, 0); wait_idle();     // R6 negative saturation
    check(sample == -12'sd2048, "R6 negative limit", int'(sample), -2048);

    issue(0, 0); repeat (30) @(negedge clk);
    issue(2, 0); repeat (30) @(negedge clk);   // R10
    issue(0, 0); repeat (20) @(negedge clk);   // R10
    issue(1, 0); wait_idle();                  // R11

    tick_en = 1'b0;                            // R12
    repeat (3) @(negedge clk);
    issue(2, 1);
    repeat (4) @(negedge clk);
    tick_en = 1'b1;
    repeat (30) @(negedge clk);
    issue(1, 1);                               // R11 R12 pre-empt on tick
    wait_idle();

    for (int n = 0; n < 60; n++) begin
      repeat ($urandom_range(0, 90)) @(negedge clk);
      issue(int'($urandom_range(0, 3)), 0);
    end
    wait_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule